// File: doc/BRIEF.md
# Paged EEPROM Write and Completion-Poll Controller

This block is the host side of a byte-wide parallel EEPROM bus. A write request gives a start address and a byte count of 1 to the page size. The bytes arrive on a ready/valid stream. For each byte the controller runs a strobe cycle: select low, then a write pulse, then a release cycle. It starts the next byte right away, so the device never sees a load gap long enough to begin programming before the page is complete. After the last byte it reads the last written address again and again until the device reports that its internal programming cycle has ended. One method compares the top data bit with the written value. The other waits until the toggling status bit holds still across two reads.

A request that would cross a page boundary is refused at once, and no strobe is issued. If the data stream runs dry after the first byte, the controller ends the page early and polls as usual. Polling is bounded: after a parameterized number of reads without completion, the controller raises an error and returns to idle. The controller also performs single reads, with select and output enable falling together and the data sampled after a parameterized access time. The tristate bus is split into a data-out vector, a data-in vector and a drive enable.

Top module: `eph_page_writer`

## Requirements
- R1: `req_ready` is high exactly when `busy` is low. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. From the next cycle on, `busy` stays high until the cycle in which `done` or `err` is raised. The one exception is a refused request, which only raises `err`.
- R2: A write request is refused, with `err` high for one cycle and no strobe at all, when `req_len` is 0 or when `req_addr[PAGE_BITS-1:0] + req_len` exceeds `2**PAGE_BITS`. With the default of 6 page bits, every byte must share address bits 12..6.
- R3: Each byte load holds `mem_ce_n` low and `mem_we_n` high for SETUP_CYC cycles. It then holds `mem_we_n` low for PULSE_CYC cycles. In the cycle after the pulse, `mem_ce_n` and `mem_we_n` are both high.
- R4: `mem_oe_n` is high in every cycle in which `mem_we_n` is low.
- R5: `mem_dq_oe` is high only while `mem_we_n` is low. `mem_oe_n` is never low in the cycle that follows a cycle with `mem_dq_oe` high.
- R6: Within one request, successive falling edges of `mem_we_n` are at most LOAD_WIN_CYC cycles apart.
- R7: The bytes of one request go to consecutive addresses, starting at `req_addr`, in stream order. Addresses past the bytes actually written are left unchanged.
- R8: If `wr_valid` is low when the next byte is due and at least one byte has already been loaded, the page ends early. Polling then starts at the last written address.
- R9: With `poll_toggle` = 0 at request time, polling reads the last written address until data bit 7 equals bit 7 of the last written byte, and then raises `done`.
- R10: With `poll_toggle` = 1 at request time, polling reads the last written address until data bit 6 has the same value on two consecutive reads, and then raises `done`.
- R11: If POLL_MAX poll reads all find the device still busy, `err` is raised for one cycle instead of `done`, and the controller is idle again.
- R12: A read request lowers `mem_ce_n` and `mem_oe_n` in the same cycle and keeps them low for ACCESS_CYC cycles. It then shows the value sampled on `mem_dq_in` in the last of those cycles on `rd_data`, and pulses `done`.
- R13: `done` and `err` are one-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request acknowledge; high while idle |
| req_write | input | 1 | 1 = page write, 0 = single read |
| req_addr | input | ADDR_W | Start address (write) or read address |
| req_len | input | PAGE_BITS+1 | Byte count of a write |
| poll_toggle | input | 1 | Completion method: 0 = data bit 7 compare, 1 = bit 6 toggle |
| wr_data | input | DATA_W | Stream byte |
| wr_valid | input | 1 | Stream byte present |
| wr_ready | output | 1 | Stream byte taken |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation completed (pulse) |
| err | output | 1 | Refused request or poll timeout (pulse) |
| rd_data | output | DATA_W | Result of the last single read |
| mem_addr | output | ADDR_W | Device address |
| mem_ce_n | output | 1 | Device select, active low |
| mem_we_n | output | 1 | Device write strobe, active low |
| mem_oe_n | output | 1 | Device output enable, active low |
| mem_dq_out | output | DATA_W | Data driven to the device |
| mem_dq_in | input | DATA_W | Data returned by the device |
| mem_dq_oe | output | 1 | Host bus drive enable |

## Verification
Some rules are checked by the embedded properties on every clock: output enable stays high during write pulses, the bus is driven only under a write pulse with a spare cycle before any read, the gap between write-pulse falling edges stays inside the load window, select and output enable fall together, and the done/err pulse rules. Other behaviour can only be shown by bench scenarios against a behavioural device that models a programming delay. These include page-boundary refusal, early end of a starved page, the exact number of poll reads under each completion method (including the toggle case where true data happens to match the last toggled value), the poll timeout, and read-back of every written byte.

// File: rtl/eph_pkg.sv
package eph_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_LOAD,
      ST_WSET,
      ST_WPUL,
      ST_WREC,
      ST_PRD,
      ST_PREC,
      ST_RRD
   } eph_state_e;
endpackage

// File: rtl/eph_timer.sv
module eph_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         expired
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (load)            cnt_q <= val;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   a_r3_timer_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && $past(cnt_q) != '0 && !$past(load)) |-> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/eph_poll_eval.sv
module eph_poll_eval (
   input  logic use_toggle,
   input  logic samp_dp,
   input  logic samp_tb,
   input  logic last_dp,
   input  logic prev_tb,
   input  logic have_prev,
   output logic complete
);
   always_comb begin
      if (use_toggle) complete = have_prev && (samp_tb == prev_tb);
      else            complete = (samp_dp == last_dp);
   end
endmodule

// File: rtl/eph_page_writer.sv
module eph_page_writer #(
   parameter int ADDR_W       = 13,
   parameter int DATA_W       = 8,
   parameter int PAGE_BITS    = 6,
   parameter int SETUP_CYC    = 2,
   parameter int PULSE_CYC    = 20,
   parameter int ACCESS_CYC   = 15,
   parameter int LOAD_WIN_CYC = 20000,
   parameter int POLL_MAX     = 4000,
   parameter int DP_BIT       = 7,
   parameter int TB_BIT       = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [PAGE_BITS:0] req_len,
   input  logic              poll_toggle,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_valid,
   output logic              wr_ready,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_dq_oe
);
   import eph_pkg::*;

   localparam int PAGE_SIZE = 1 << PAGE_BITS;
   localparam int MAXC_A    = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
   localparam int MAXC      = (MAXC_A > ACCESS_CYC) ? MAXC_A : ACCESS_CYC;
   localparam int TW        = $clog2(MAXC) + 1;
   localparam int PW        = $clog2(POLL_MAX + 1);
   localparam int BYTE_GAP  = SETUP_CYC + PULSE_CYC + 2;

   generate
      if (PAGE_BITS < 1 || PAGE_BITS >= ADDR_W) begin : g_chk_page
         $error("page bits must lie inside the address");
      end
      if (SETUP_CYC < 1 || PULSE_CYC < 1 || ACCESS_CYC < 1) begin : g_chk_cyc
         $error("strobe phases need at least one cycle");
      end
      if (BYTE_GAP >= LOAD_WIN_CYC) begin : g_chk_win
         $error("byte load period does not fit the load window");
      end
      if (DP_BIT >= DATA_W || TB_BIT >= DATA_W || POLL_MAX < 1) begin : g_chk_poll
         $error("status bit or poll limit out of range");
      end
   endgenerate

   eph_state_e             state_q;
   logic [ADDR_W-1:0]      addr_q;
   logic [PAGE_BITS:0]     left_q;
   logic [DATA_W-1:0]      byte_q, rd_q;
   logic                   first_q, mode_q, last_dp_q;
   logic                   samp_dp_q, samp_tb_q, prev_tb_q, have_prev_q;
   logic [PW-1:0]          polls_q;
   logic                   done_q, err_q;

   logic [PAGE_BITS+1:0]   span_w;
   logic                   bad_req, accept, take, dry, poll_start, poll_last;
   logic                   tmr_load, tmr_exp, complete;
   logic [TW-1:0]          tmr_val;

   assign span_w  = {2'b00, req_addr[PAGE_BITS-1:0]} + {1'b0, req_len};
   assign bad_req = (req_len == '0) || (span_w > (PAGE_BITS+2)'(PAGE_SIZE));

   assign accept     = (state_q == ST_IDLE) && req_valid;
   assign take       = (state_q == ST_LOAD) && wr_valid;
   assign dry        = (state_q == ST_LOAD) && !wr_valid && !first_q;
   assign poll_last  = (polls_q == PW'(POLL_MAX - 1));
   assign poll_start = dry
                     || ((state_q == ST_WREC) && (left_q == '0))
                     || ((state_q == ST_PREC) && !complete && !poll_last);

   assign tmr_load = (accept && !req_write) || poll_start || take
                   || ((state_q == ST_WSET) && tmr_exp);

   always_comb begin
      if (take)                       tmr_val = TW'(SETUP_CYC - 1);
      else if (state_q == ST_WSET)    tmr_val = TW'(PULSE_CYC - 1);
      else                            tmr_val = TW'(ACCESS_CYC - 1);
   end

   eph_timer #(.W(TW)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .val     (tmr_val),
      .expired (tmr_exp)
   );

   eph_poll_eval u_eval (
      .use_toggle (mode_q),
      .samp_dp    (samp_dp_q),
      .samp_tb    (samp_tb_q),
      .last_dp    (last_dp_q),
      .prev_tb    (prev_tb_q),
      .have_prev  (have_prev_q),
      .complete   (complete)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         addr_q      <= '0;
         left_q      <= '0;
         byte_q      <= '0;
         rd_q        <= '0;
         first_q     <= 1'b0;
         mode_q      <= 1'b0;
         last_dp_q   <= 1'b0;
         samp_dp_q   <= 1'b0;
         samp_tb_q   <= 1'b0;
         prev_tb_q   <= 1'b0;
         have_prev_q <= 1'b0;
         polls_q     <= '0;
         done_q      <= 1'b0;
         err_q       <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         if (poll_start) begin
            state_q <= ST_PRD;
            if (state_q == ST_PREC) begin
               polls_q     <= polls_q + 1'b1;
               prev_tb_q   <= samp_tb_q;
               have_prev_q <= 1'b1;
            end else begin
               polls_q     <= '0;
               have_prev_q <= 1'b0;
            end
         end else begin
            unique case (state_q)
               ST_IDLE: if (accept) begin
                  addr_q <= req_addr;
                  if (!req_write) state_q <= ST_RRD;
                  else if (bad_req) err_q <= 1'b1;
                  else begin
                     left_q  <= req_len;
                     first_q <= 1'b1;
                     mode_q  <= poll_toggle;
                     state_q <= ST_LOAD;
                  end
               end
               ST_LOAD: if (take) begin
                  byte_q  <= wr_data;
                  if (!first_q) addr_q <= addr_q + 1'b1;
                  state_q <= ST_WSET;
               end
               ST_WSET: if (tmr_exp) state_q <= ST_WPUL;
               ST_WPUL: if (tmr_exp) begin
                  last_dp_q <= byte_q[DP_BIT];
                  first_q   <= 1'b0;
                  left_q    <= left_q - 1'b1;
                  state_q   <= ST_WREC;
               end
               ST_WREC: state_q <= ST_LOAD;
               ST_PRD: if (tmr_exp) begin
                  samp_dp_q <= mem_dq_in[DP_BIT];
                  samp_tb_q <= mem_dq_in[TB_BIT];
                  state_q   <= ST_PREC;
               end
               ST_PREC: begin
                  if (complete) done_q <= 1'b1;
                  else          err_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
               ST_RRD: if (tmr_exp) begin
                  rd_q    <= mem_dq_in;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign req_ready  = (state_q == ST_IDLE);
   assign busy       = (state_q != ST_IDLE);
   assign wr_ready   = (state_q == ST_LOAD);
   assign done       = done_q;
   assign err        = err_q;
   assign rd_data    = rd_q;
   assign mem_addr   = addr_q;
   assign mem_ce_n   = !(state_q inside {ST_WSET, ST_WPUL, ST_PRD, ST_RRD});
   assign mem_we_n   = (state_q != ST_WPUL);
   assign mem_oe_n   = !(state_q inside {ST_PRD, ST_RRD});
   assign mem_dq_out = byte_q;
   assign mem_dq_oe  = (state_q == ST_WPUL);

   // load-window watch: cycles since the last write-strobe falling edge
   logic        we_d;
   logic [31:0] gap_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_d  <= 1'b1;
         gap_q <= '0;
      end else begin
         we_d <= mem_we_n;
         if (!mem_we_n && we_d) gap_q <= '0;
         else if (gap_q != '1)  gap_q <= gap_q + 1'b1;
      end
   end

   a_r6_load_window: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && we_d && !first_q) |-> (gap_q < 32'(LOAD_WIN_CYC)));
   a_r4_oe_high_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_oe_n);
   a_r5_drive_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> !mem_we_n);
   a_r5_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |=> mem_oe_n);
   a_r12_ce_with_oe: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_oe_n) |-> $fell(mem_ce_n));
   a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (busy || err));
   a_r13_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r13_done_err_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));
endmodule

// File: tb/test_eph_page_writer.sv
module test_eph_page_writer;
   localparam int SETUP = 2, PULSE = 3, ACCESS = 2, LWIN = 16, PMAX = 20;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       req_valid = 0, req_write = 0, poll_toggle = 0, wr_valid = 0;
   logic [12:0] req_addr = '0;
   logic [6:0]  req_len = '0;
   logic [7:0]  wr_data = '0, mem_dq_in = '0;
   logic        req_ready, wr_ready, busy, done, err;
   logic [7:0]  rd_data, mem_dq_out;
   logic [12:0] mem_addr;
   logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;

   always #2.5 clk = ~clk;

   eph_page_writer #(.SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .ACCESS_CYC(ACCESS),
                     .LOAD_WIN_CYC(LWIN), .POLL_MAX(PMAX)) i_eph_page_writer (
      .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_len,
      .poll_toggle, .wr_data, .wr_valid, .wr_ready, .busy, .done, .err, .rd_data,
      .mem_addr, .mem_ce_n, .mem_we_n, .mem_oe_n, .mem_dq_out, .mem_dq_in, .mem_dq_oe);

   int total = 0, bad = 0;
   bit finished = 0;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural device and protocol monitor ----------------
   logic [7:0]  dmem [int];
   logic [7:0]  exp_mem [int];
   logic [12:0] pend_a [$];
   logic [7:0]  pend_d [$];
   logic [12:0] cur_a = '0, last_a = '0;
   logic [7:0]  cur_d = '0, last_d = '0;
   int  busy_cfg = 0, busy_left = 0, nreads = 0, nwe = 0, nce = 0;
   int  setup_cnt = 0, low_cnt = 0, oe_cnt = 0, gap = 0;
   bit  tog = 0, in_page = 0;
   logic prev_we = 1, prev_oe = 1, prev_ce = 1, prev_dqoe = 0, prev_done = 0;

   always @(negedge clk) if (rst_n) begin
      chk(mem_we_n || mem_oe_n, "R4", "oe low during pulse", mem_oe_n, 1);
      chk(!mem_dq_oe || !mem_we_n, "R5", "drive outside pulse", mem_dq_oe, 0);
      chk(!prev_dqoe || mem_oe_n, "R5", "turnaround", mem_oe_n, 1);
      chk(req_ready == !busy, "R1", "ready vs busy", req_ready, !busy);
      chk(!(prev_done && done) && !(done && err), "R13", "pulse shape", done, 0);

      if (!mem_ce_n && !mem_we_n) begin cur_a = mem_addr; cur_d = mem_dq_out; end
      if (prev_we && !mem_we_n) begin
         nwe++;
         chk(setup_cnt == SETUP, "R3", "setup cycles", setup_cnt, SETUP);
         if (in_page) chk(gap <= LWIN, "R6", "load gap", gap, LWIN);
         in_page = 1; gap = 0; low_cnt = 0;
      end
      if (!mem_we_n) low_cnt++;
      if (!prev_we && mem_we_n) begin
         chk(low_cnt == PULSE, "R3", "pulse cycles", low_cnt, PULSE);
         chk(mem_ce_n, "R3", "select released", mem_ce_n, 1);
         pend_a.push_back(cur_a); pend_d.push_back(cur_d);
      end
      if (!mem_ce_n && mem_we_n && mem_oe_n) setup_cnt++; else setup_cnt = 0;
      if (in_page) gap++;
      if (prev_ce && !mem_ce_n) nce++;

      if (prev_oe && !mem_oe_n) begin
         chk(prev_ce && !mem_ce_n, "R12", "select with oe", mem_ce_n, 0);
         in_page = 0; nreads++; oe_cnt = 0;
         if (pend_a.size() > 0) begin
            foreach (pend_a[i]) dmem[int'(pend_a[i])] = pend_d[i];
            last_a = pend_a[$]; last_d = pend_d[$];
            pend_a.delete(); pend_d.delete();
            busy_left = busy_cfg; tog = 0;
         end
         if (busy_left > 0 && mem_addr == last_a)
            mem_dq_in = {~last_d[7], tog, last_d[5:0]};
         else if (dmem.exists(int'(mem_addr))) mem_dq_in = dmem[int'(mem_addr)];
         else mem_dq_in = 8'hFF;
      end
      if (!mem_oe_n) oe_cnt++;
      if (!prev_oe && mem_oe_n) begin
         chk(oe_cnt == ACCESS, "R12", "access cycles", oe_cnt, ACCESS);
         if (busy_left > 0) begin busy_left--; tog = ~tog; end
      end
      prev_we = mem_we_n; prev_oe = mem_oe_n; prev_ce = mem_ce_n;
      prev_dqoe = mem_dq_oe; prev_done = done;
   end

   // ---------------- stream source ----------------
   logic [7:0] feed [$];
   bit hs_pend = 0;
   always @(negedge clk) begin
      if (hs_pend) void'(feed.pop_front());
      wr_valid = (feed.size() > 0);
      if (wr_valid) wr_data = feed[0];
      hs_pend = wr_valid && wr_ready;
   end

   // ---------------- reference for poll counts ----------------
   function automatic int exp_polls(bit tmode, int bsy, logic [7:0] lb);
      bit vp = 0;
      if (!tmode) return (bsy >= PMAX) ? PMAX : bsy + 1;
      for (int i = 0; i < PMAX; i++) begin
         bit v = (i < bsy) ? bit'(i % 2) : lb[6];
         if (i >= 1 && v == vp) return i + 1;
         vp = v;
      end
      return PMAX;
   endfunction

   int seed = 11;

   task automatic issue(bit wr, int addr, int len, bit tmode);
      @(negedge clk);
      req_valid = 1; req_write = wr; req_addr = 13'(addr); req_len = 7'(len);
      poll_toggle = tmode;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 0;
      while (!(done || err)) @(negedge clk);
   endtask

   task automatic do_write(int addr, int len, int nfeed, bit tmode, int bsy,
                           bit exp_err, string req);
      int r0 = nreads, w0 = nwe, c0 = nce;
      logic [7:0] lb = '0;
      int ew;
      for (int i = 0; i < nfeed; i++) begin
         logic [7:0] b = 8'(addr + i * 37 + seed);
         feed.push_back(b);
         exp_mem[addr + i] = b;
         lb = b;
      end
      seed += 29;
      busy_cfg = bsy;
      issue(1, addr, len, tmode);
      chk(err == exp_err, req, "err flag", err, exp_err);
      chk(done == !exp_err, req, "done flag", done, !exp_err);
      ew = (nfeed == 0) ? 0 : exp_polls(tmode, bsy, lb);
      chk(nwe - w0 == nfeed, req, "write pulses", nwe - w0, nfeed);
      chk(nreads - r0 == ew, req, "poll reads", nreads - r0, ew);
      if (nfeed == 0) chk(nce == c0, req, "no strobe", nce - c0, 0);
      if (!exp_err) chk(busy_left == 0, req, "done while device busy", busy_left, 0);
      feed.delete();
      busy_left = 0;
      @(negedge clk);
      chk(!busy && req_ready, "R1", "idle after end", busy, 0);
   endtask

   task automatic do_read(int addr, string req);
      logic [7:0] e = exp_mem.exists(addr) ? exp_mem[addr] : 8'hFF;
      issue(0, addr, 1, 0);
      chk(done && rd_data == e, req, $sformatf("read %0h", addr), rd_data, e);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(!busy && req_ready && !done && !err, "R1", "reset idle", busy, 0);
      chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R3", "reset strobes",
          {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);

      do_write(13'h0040, 4, 4, 0, 3, 0, "R9");          // data-bit polling
      for (int i = 0; i < 5; i++) do_read(13'h0040 + i, "R7");
      do_write(13'h1FF8, 8, 8, 1, 5, 0, "R10");         // toggle polling, page tail
      for (int i = 0; i < 8; i++) do_read(13'h1FF8 + i, "R7");
      do_write(13'h0100, 64, 64, 1, 0, 0, "R10");       // full page, ready at once
      for (int i = 0; i < 64; i++) do_read(13'h0100 + i, "R12");
      do_write(13'h0500, 3, 3, 1, 4, 0, "R10");
      do_write(13'h007F, 2, 0, 0, 0, 1, "R2");          // crosses a page
      do_write(13'h0200, 0, 0, 0, 0, 1, "R2");          // zero length
      do_write(13'h0000, 65, 0, 0, 0, 1, "R2");         // beyond page size
      do_read(13'h0080, "R2");
      do_write(13'h0300, 10, 3, 0, 2, 0, "R8");         // stream runs dry
      for (int i = 0; i < 5; i++) do_read(13'h0300 + i, "R8");
      do_write(13'h0400, 1, 1, 0, 100, 1, "R11");       // poll limit
      do_read(13'h0400, "R11");

      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog run did not end actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule